// File: doc/BRIEF.md
# Dual Masked Alarm with Shared Interrupt / Frequency Pin

This block watches a running clock/calendar and compares it against two independent alarm register sets. Every alarm field carries its own enable bit, so one alarm can fire on any subset of fields: every minute, every Tuesday, or a full month/date/hour/minute match. The compare happens only on the seconds tick strobe, so each matching second yields exactly one event.

An event sets a sticky per-alarm status flag that the host polls and clears with a one-cycle clear pulse. Each alarm is armed by a host pulse. In one-shot mode it disarms itself when it fires. In repeat mode it stays armed and fires on every later matching tick.

A single output pin is shared. With the pin select at 00 it carries an active-low interrupt, driven low while any flag whose interrupt enable is set is high. The other three select codes turn it into a square wave taken from a free-running prescaler. The time counting and the host bus live outside the block.

Top module: `alarm_irq_unit`

## Requirements
- R1: Field k of the time input occupies now_i[8k+7:8k] (k=0 second, 1 minute, 2 hour, 3 date, 4 month, 5 weekday). Alarm a field k is alm_val_i[(6a+k)*8 +: 8], with enable alm_en_i[6a+k]. An armed alarm whose enabled fields all equal the time fields on a tick sets flag_o[a]. Disabled fields are ignored.
- R2: An alarm with all six enable bits at 0 never sets its flag.
- R3: The compare is made only in cycles where tick_i is 1. The flag becomes visible after the clock edge that samples the tick. A matching time without a tick sets nothing.
- R4: A flag stays set until a clr_i[a] pulse. If a firing tick and a clear arrive in the same cycle, the flag stays set.
- R5: With repeat_i[a]=0, firing clears armed_o[a]. Later matching ticks set no flag until arm_i[a] is pulsed.
- R6: With repeat_i[a]=1, armed_o[a] stays 1 after firing, and each later matching tick sets the flag again.
- R7: With pin_sel_i=00, pin_o is 0 while any flag_o[a] with irq_en_i[a]=1 is set, and 1 otherwise.
- R8: With pin_sel_i at 01, 10 or 11, pin_o is a square wave whose level holds for 1, 8 or 32768 clock cycles respectively, regardless of the flags. At a 65.536 kHz clock this gives 32.768 kHz, 4096 Hz and 1 Hz.
- R9: The two alarms are independent. A match of one alarm does not set the other's flag.
- R10: After reset all flags and armed bits are 0, and pin_o is 1 with pin_sel_i=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (prescaler reference) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle seconds strobe |
| now_i | input | 48 | Current BCD time fields |
| alm_val_i | input | 96 | Alarm compare values, two sets of six fields |
| alm_en_i | input | 12 | Per-field compare enables |
| arm_i | input | 2 | Arm pulse per alarm |
| repeat_i | input | 2 | Repeat mode per alarm |
| irq_en_i | input | 2 | Interrupt enable per alarm |
| clr_i | input | 2 | Flag clear pulse per alarm |
| pin_sel_i | input | 2 | Pin function: 00 irq, 01 fast, 10 mid, 11 slow |
| flag_o | output | 2 | Sticky alarm status flags |
| armed_o | output | 2 | Alarm armed state |
| pin_o | output | 1 | Shared interrupt / frequency pin |

## Verification
Several properties are checked on every cycle:
- flags only rise on a tick;
- flags hold without a clear, and a set beats a clear;
- one-shot alarms disarm and repeat alarms stay armed;
- an alarm with no enabled fields stays silent;
- the pin is low in interrupt mode whenever an enabled flag is set.

Other behaviour can only be shown by the bench's scenarios:
- whether a given mask pattern really matches or rejects a given time;
- the exact half-periods of the three divided outputs;
- the independence of the two alarms.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FIELD_W  = 8;
  localparam int N_FIELDS = 6;
  localparam int N_ALARMS = 2;

  typedef enum logic [1:0] {
    PIN_IRQ  = 2'b00,
    PIN_FAST = 2'b01,
    PIN_MID  = 2'b10,
    PIN_SLOW = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int NF = 6,
  parameter int FW = 8
) (
  input  logic [NF*FW-1:0] now_i,
  input  logic [NF*FW-1:0] val_i,
  input  logic [NF-1:0]    en_i,
  output logic             hit_o
);
  logic [NF-1:0] fld_ok;

  for (genvar k = 0; k < NF; k++) begin : g_fld
    assign fld_ok[k] = !en_i[k] || (now_i[k*FW +: FW] == val_i[k*FW +: FW]);
  end

  // an empty mask must never match
  assign hit_o = (|en_i) && (&fld_ok);
endmodule

// File: rtl/alarm_slot.sv
module alarm_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic arm_i,
  input  logic repeat_i,
  input  logic clr_i,
  output logic flag_o,
  output logic armed_o
);
  logic armed_q, flag_q, fire;

  assign fire = tick_i && armed_q && match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
    end else if (fire && !repeat_i) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (fire) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  AST_SET_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !flag_q) |=> !flag_q); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && armed_q && match_i) |=> flag_q); // R4
  AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && armed_q && match_i && !repeat_i && !arm_i) |=> !armed_q); // R5
  AST_REPEAT_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && repeat_i) |=> armed_q); // R6
endmodule

// File: rtl/freq_div.sv
module freq_div
  import alarm_pkg::*;
#(
  parameter int FAST_BIT = 0,
  parameter int MID_BIT  = 3,
  parameter int SLOW_BIT = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       irq_n_i,
  output logic       pin_o
);
  localparam int CNT_W = SLOW_BIT + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (pin_sel_e'(sel_i))
      PIN_FAST: pin_o = cnt_q[FAST_BIT];
      PIN_MID:  pin_o = cnt_q[MID_BIT];
      PIN_SLOW: pin_o = cnt_q[SLOW_BIT];
      default:  pin_o = irq_n_i;
    endcase
  end

  AST_FAST_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == PIN_FAST && FAST_BIT == 0) |=> (sel_i != PIN_FAST) || (pin_o != $past(pin_o))); // R8
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
#(
  parameter int NA       = N_ALARMS,
  parameter int NF       = N_FIELDS,
  parameter int FW       = FIELD_W,
  parameter int FAST_BIT = 0,
  parameter int MID_BIT  = 3,
  parameter int SLOW_BIT = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NF*FW-1:0]    now_i,
  input  logic [NA*NF*FW-1:0] alm_val_i,
  input  logic [NA*NF-1:0]    alm_en_i,
  input  logic [NA-1:0]       arm_i,
  input  logic [NA-1:0]       repeat_i,
  input  logic [NA-1:0]       irq_en_i,
  input  logic [NA-1:0]       clr_i,
  input  logic [1:0]          pin_sel_i,
  output logic [NA-1:0]       flag_o,
  output logic [NA-1:0]       armed_o,
  output logic                pin_o
);
  localparam int SET_W = NF * FW;

  logic irq_n;

  for (genvar a = 0; a < NA; a++) begin : g_alm
    logic match;

    alarm_cmp #(.NF(NF), .FW(FW)) u_cmp (
      .now_i (now_i),
      .val_i (alm_val_i[a*SET_W +: SET_W]),
      .en_i  (alm_en_i[a*NF +: NF]),
      .hit_o (match)
    );

    alarm_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .match_i  (match),
      .arm_i    (arm_i[a]),
      .repeat_i (repeat_i[a]),
      .clr_i    (clr_i[a]),
      .flag_o   (flag_o[a]),
      .armed_o  (armed_o[a])
    );

    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((alm_en_i[a*NF +: NF] == '0) && !flag_o[a]) |=> !flag_o[a]); // R2
  end

  assign irq_n = ~|(flag_o & irq_en_i);

  freq_div #(
    .FAST_BIT (FAST_BIT),
    .MID_BIT  (MID_BIT),
    .SLOW_BIT (SLOW_BIT)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (pin_sel_i),
    .irq_n_i (irq_n),
    .pin_o   (pin_o)
  );

  AST_PIN_LOW_ON_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_i == PIN_IRQ && |(flag_o & irq_en_i)) |-> !pin_o); // R7
  AST_PIN_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_i == PIN_IRQ && !(|(flag_o & irq_en_i))) |-> pin_o); // R7
endmodule

// File: tb/alarm_irq_unit_test.sv
module alarm_irq_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic [47:0] now = '0;
  logic [95:0] alm_val = '0;
  logic [11:0] alm_en = '0;
  logic [1:0]  arm = '0, rpt = '0, irq_en = '0, clr = '0, psel = '0;
  logic [1:0]  flag, armed;
  logic        pin;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  alarm_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .now_i(now),
    .alm_val_i(alm_val), .alm_en_i(alm_en), .arm_i(arm), .repeat_i(rpt),
    .irq_en_i(irq_en), .clr_i(clr), .pin_sel_i(psel),
    .flag_o(flag), .armed_o(armed), .pin_o(pin)
  );

  // fields, LSB first: sec, min, hour, date, month, weekday
  localparam logic [47:0] T_A = {8'h02, 8'h03, 8'h21, 8'h05, 8'h23, 8'h30};
  localparam logic [47:0] T_B = {8'h06, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58};

  typedef struct packed {
    logic [5:0]  en;
    logic [47:0] tm;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{6'b000010, {8'h04, 8'h07, 8'h01, 8'h11, 8'h23, 8'h00}, 1'b1},
    '{6'b000010, {8'h02, 8'h03, 8'h21, 8'h05, 8'h24, 8'h30}, 1'b0},
    '{6'b100000, {8'h02, 8'h09, 8'h14, 8'h17, 8'h41, 8'h05}, 1'b1},
    '{6'b011110, {8'h05, 8'h03, 8'h21, 8'h05, 8'h23, 8'h11}, 1'b1},
    '{6'b011110, {8'h02, 8'h04, 8'h21, 8'h05, 8'h23, 8'h30}, 1'b0},
    '{6'b000000, T_A, 1'b0},
    '{6'b111111, T_A, 1'b1},
    '{6'b111111, {8'h02, 8'h03, 8'h21, 8'h05, 8'h23, 8'h31}, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    @(negedge clk) clr = m;
    @(negedge clk) clr = '0;
  endtask

  task automatic pulse_arm(input logic [1:0] m);
    @(negedge clk) arm = m;
    @(negedge clk) arm = '0;
  endtask

  task automatic level_gap(output int g);
    logic p;
    int n;
    @(negedge clk);
    p = pin;
    n = 0;
    while (pin == p && n < 100000) begin @(negedge clk); n++; end
    p = pin;
    n = 0;
    do begin @(negedge clk); n++; end while (pin == p && n < 100000);
    g = n;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int g;
    alm_val = {T_B, T_A};
    alm_en  = {6'b111111, 6'b000000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 flags", flag, 2'b00);
    chk("R10 armed", armed, 2'b00);
    chk("R10 pin", pin, 1'b1);

    rpt = 2'b01;
    pulse_arm(2'b11);
    chk("R6 armed after arm", armed, 2'b11);

    // R1 R2 mask patterns on alarm 0, alarm 1 stays quiet (R9)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      alm_en[5:0] = VEC[i].en;
      now = VEC[i].tm;
      pulse_clr(2'b11);
      pulse_tick();
      chk($sformatf("R1 vec%0d flag0", i), flag[0], VEC[i].exp);
      chk($sformatf("R9 vec%0d flag1", i), flag[1], 1'b0);
    end

    // R5 one-shot on alarm 1
    pulse_clr(2'b11);
    @(negedge clk) now = T_B;
    pulse_tick();
    chk("R5 fire flag1", flag[1], 1'b1);
    chk("R9 flag0 quiet", flag[0], 1'b0);
    chk("R5 disarmed", armed[1], 1'b0);
    pulse_clr(2'b10);
    pulse_tick();
    chk("R5 no refire", flag[1], 1'b0);
    pulse_arm(2'b10);
    pulse_tick();
    chk("R5 rearm fires", flag[1], 1'b1);

    // R6 repeat on alarm 0
    pulse_clr(2'b11);
    @(negedge clk) now = T_A;
    pulse_tick();
    chk("R6 fire flag0", flag[0], 1'b1);
    chk("R6 still armed", armed[0], 1'b1);
    pulse_clr(2'b01);
    chk("R4 cleared", flag[0], 1'b0);
    pulse_tick();
    chk("R6 refire", flag[0], 1'b1);

    // R4 sticky and set beats clear
    repeat (5) @(negedge clk);
    chk("R4 sticky", flag[0], 1'b1);
    @(negedge clk) begin tick = 1; clr = 2'b01; end
    @(negedge clk) begin tick = 0; clr = 2'b00; end
    chk("R4 set wins", flag[0], 1'b1);

    // R3 no tick, no compare
    pulse_clr(2'b01);
    repeat (4) @(negedge clk);
    chk("R3 no tick", flag[0], 1'b0);

    // R7 interrupt pin
    pulse_tick();
    chk("R7 masked irq", pin, 1'b1);
    @(negedge clk) irq_en = 2'b01;
    @(negedge clk);
    chk("R7 irq low", pin, 1'b0);
    pulse_clr(2'b01);
    chk("R7 irq released", pin, 1'b1);

    // R8 frequency modes with a pending flag
    pulse_tick();
    chk("R7 irq low again", pin, 1'b0);
    @(negedge clk) psel = 2'b01;
    level_gap(g);
    chk("R8 fast gap", g, 1);
    @(negedge clk) psel = 2'b10;
    level_gap(g);
    chk("R8 mid gap", g, 8);
    @(negedge clk) psel = 2'b11;
    level_gap(g);
    chk("R8 slow gap", g, 32768);
    @(negedge clk) psel = 2'b00;
    @(negedge clk);
    chk("R7 back to irq", pin, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule